// File: doc/BRIEF.md
# Multiply and Divide Unit with Quotient Extension Register

This block is a multi-cycle 32-bit integer multiply and divide engine. It works with a 32-bit extension register, called MQ here, that it keeps inside the block and also drives out. A multiply produces a 64-bit product. The high half is returned as the result and the low half is left in MQ. A two-word divide uses MQ as the low half of a 64-bit dividend and leaves the remainder there. A single-word divide uses only the first operand as its dividend. Each operation has a plain form and an overflow-recording form. The recording form updates an overflow bit (OV) and a sticky summary bit (SO).

The caller places two operands and an operation code on the inputs and raises `start_i` for one cycle while the unit is idle. When the unit raises `done_o` for one cycle, the result, MQ, OV and SO are valid. They stay valid until the next accepted start. A divide runs a 32-step restoring division on operand magnitudes and then corrects the signs. A multiply either completes in one registered step or runs a shift-add loop, chosen by a parameter.

Top module: `mdu_mq_unit`

## Requirements
- R1: The operation code is decoded as follows. `op_i[2:1]` = 00 is multiply, 01 is two-word divide, 10 is single-word signed divide, and 11 behaves as multiply. `op_i[0]` = 1 selects the overflow-recording form. A multiply treats both operands as unsigned, returns bits 63..32 of the product as the result and writes bits 31..0 to MQ.
- R2: A recording multiply sets OV and SO when the 64-bit product differs from the sign extension of its low 32 bits, and otherwise clears OV. A plain multiply or a plain divide leaves OV and SO unchanged.
- R3: A two-word divide takes the signed 64-bit dividend {a_i, MQ} and the signed divisor b_i. The quotient truncates toward zero and goes to the result. The remainder takes the sign of the dividend and goes to MQ.
- R4: A single-word divide takes the signed dividend a_i and the signed divisor b_i. The quotient goes to the result and the remainder to MQ, with the same sign rules as R3.
- R5: Two cases are special: a divisor of zero, and a divisor of all ones when the low dividend word is 0x80000000. In either case the result is 0x80000000 and MQ is cleared. The recording forms also set OV and SO.
- R6: A divide whose quotient magnitude is 2^32 or more gives the same result and MQ as R5, and the recording form sets OV and SO. Otherwise the result is the low 32 bits of the signed quotient. The recording form then sets OV and SO if the quotient lies outside the signed 32-bit range, and clears OV if it lies inside.
- R7: SO is sticky. No operation ever clears it; only reset does.
- R8: `done_o` is high for exactly one cycle per accepted start. The result, MQ, OV and SO do not change from that pulse until the next accepted start. A start that arrives while an operation is in progress is ignored.
- R9: A synchronous active-high reset clears the result, MQ, OV, SO and `done_o`, and abandons any operation in progress, so that no completion pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 3 | Operation kind (bits 2..1) and overflow-recording select (bit 0) |
| a_i | input | W | First operand; the high dividend word for a two-word divide |
| b_i | input | W | Second operand or divisor |
| result_o | output | W | Product high half or quotient |
| mq_o | output | W | Extension register: product low half or remainder |
| ov_o | output | 1 | Overflow from the last recording operation |
| so_o | output | 1 | Sticky summary overflow |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the sign corners of division:
- A negative dividend over a positive divisor, and the reverse. A design that took the remainder's sign from the divisor would return a remainder of the wrong sign.
- A quotient of exactly -2^31. A design that rejected it would raise OV on a quotient that fits.
- A quotient of +2^31, which does not fit in a signed 32-bit value and must raise OV.

It also checks that a two-word divide really reads MQ. An MQ value is first loaded by a multiply; a design that ignored MQ would return a quotient off by the low word.

Further cases:
- The two special divides and the oversize-quotient case must return 0x80000000 with MQ cleared. A design that skipped them would divide by zero or return a truncated quotient.
- A `mulo` with a product of exactly 0x80000000 must report overflow, because the product's sign extension differs from the unsigned product.
- SO must survive a later operation without overflow.
- A start issued in the middle of a divide must neither corrupt the divide nor produce a second completion pulse.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   // Operation kind, carried in bits 2..1 of the operation code.
   typedef enum logic [1:0] {
      K_MUL  = 2'b00,
      K_DIVW = 2'b01,
      K_DIVS = 2'b10,
      K_RSV  = 2'b11
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  rec_ov;
   } op_t;

   typedef enum logic [1:0] {
      S_IDLE,
      S_MUL,
      S_DIV,
      S_SPEC
   } state_e;

endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
   parameter int W      = 32,
   parameter bit SERIAL = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           go_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic           fin_o,
   output logic [2*W-1:0] prod_o
);
   localparam int CW = $clog2(W + 1);

   generate
      if (SERIAL) begin : g_serial
         logic [W-1:0]  a_q, hi_q, lo_q;
         logic [CW-1:0] cnt_q;
         logic          fin_q;
         logic [W:0]    sum;

         // Add the multiplicand when the current multiplier bit is set.
         assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, a_q} : '0);

         always_ff @(posedge clk) begin
            if (rst) begin
               a_q   <= '0;
               hi_q  <= '0;
               lo_q  <= '0;
               cnt_q <= '0;
               fin_q <= 1'b0;
            end else begin
               fin_q <= 1'b0;
               if (go_i) begin
                  a_q   <= a_i;
                  hi_q  <= '0;
                  lo_q  <= b_i;
                  cnt_q <= CW'(W);
               end else if (cnt_q != '0) begin
                  hi_q  <= sum[W:1];
                  lo_q  <= {sum[0], lo_q[W-1:1]};
                  cnt_q <= cnt_q - 1'b1;
                  fin_q <= (cnt_q == CW'(1));
               end
            end
         end

         assign fin_o  = fin_q;
         assign prod_o = {hi_q, lo_q};

         AST_MUL_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
            fin_q |=> !fin_q);                                    // R8
      end else begin : g_single
         logic [2*W-1:0] prod_q;
         logic           fin_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               prod_q <= '0;
               fin_q  <= 1'b0;
            end else begin
               fin_q <= go_i;
               if (go_i) prod_q <= {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
            end
         end

         assign fin_o  = fin_q;
         assign prod_o = prod_q;
      end
   endgenerate

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         go_i,
   input  logic [W-1:0] num_hi_i,
   input  logic [W-1:0] num_lo_i,
   input  logic [W-1:0] den_i,
   output logic         fin_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  den_q, rem_q, quo_q;
   logic [CW-1:0] cnt_q;
   logic          fin_q;
   logic [W:0]    shifted, trial;

   // One restoring step: shift in the next dividend bit, then try to subtract.
   assign shifted = {rem_q, quo_q[W-1]};
   assign trial   = shifted - {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         den_q <= '0;
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go_i) begin
            den_q <= den_i;
            rem_q <= num_hi_i;
            quo_q <= num_lo_i;
            cnt_q <= CW'(W);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            fin_q <= (cnt_q == CW'(1));
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
         end
      end
   end

   assign fin_o = fin_q;
   assign quo_o = quo_q;
   assign rem_o = rem_q;

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
      fin_q |-> (rem_q < den_q));                                 // R3

endmodule

// File: rtl/mdu_mq_unit.sv
module mdu_mq_unit
   import mdu_pkg::*;
#(
   parameter int W          = 32,
   parameter bit MUL_SERIAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start_i,
   input  logic [2:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] result_o,
   output logic [W-1:0] mq_o,
   output logic         ov_o,
   output logic         so_o,
   output logic         done_o
);
   localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

   initial assert (W >= 4 && (W % 2) == 0)
      else $error("mdu_mq_unit: W must be even and at least 4");

   state_e         state_q;
   logic           rec_q, neg_q_q, neg_r_q;
   logic [W-1:0]   result_q, mq_q;
   logic           ov_q, so_q, done_q;

   op_t            op_in;
   logic           accept, is_div_in, special, too_big, div_go, mul_go;
   logic [2*W-1:0] dividend, mag_n;
   logic [W-1:0]   mag_d;
   logic           neg_n, neg_d;

   assign op_in     = op_t'(op_i);
   assign accept    = start_i && (state_q == S_IDLE);
   assign is_div_in = (op_in.kind == K_DIVW) || (op_in.kind == K_DIVS);

   // Dividend and divisor are prepared as signs plus magnitudes.
   assign dividend = (op_in.kind == K_DIVW) ? {a_i, mq_q} : {{W{a_i[W-1]}}, a_i};
   assign neg_n    = dividend[2*W-1];
   assign neg_d    = b_i[W-1];
   assign mag_n    = neg_n ? (~dividend + 1'b1) : dividend;
   assign mag_d    = neg_d ? (~b_i + 1'b1) : b_i;
   assign special  = (b_i == '0) || ((dividend[W-1:0] == MIN_WORD) && (b_i == '1));
   assign too_big  = (mag_n[2*W-1:W] >= mag_d);
   assign div_go   = accept && is_div_in && !special && !too_big;
   assign mul_go   = accept && !is_div_in;

   logic           mul_fin;
   logic [2*W-1:0] prod;
   logic           mul_ov;

   mdu_mul_core #(.W(W), .SERIAL(MUL_SERIAL)) u_mul (
      .clk(clk), .rst(rst), .go_i(mul_go), .a_i(a_i), .b_i(b_i),
      .fin_o(mul_fin), .prod_o(prod)
   );

   assign mul_ov = (prod[2*W-1:W] != {W{prod[W-1]}});

   logic           div_fin;
   logic [W-1:0]   q_mag, r_mag, q_fixed, r_fixed;
   logic           q_fits;

   mdu_div_core #(.W(W)) u_div (
      .clk(clk), .rst(rst), .go_i(div_go),
      .num_hi_i(mag_n[2*W-1:W]), .num_lo_i(mag_n[W-1:0]), .den_i(mag_d),
      .fin_o(div_fin), .quo_o(q_mag), .rem_o(r_mag)
   );

   // Sign correction: quotient sign is the XOR of the operand signs,
   // remainder sign follows the dividend.
   assign q_fixed = neg_q_q ? (~q_mag + 1'b1) : q_mag;
   assign r_fixed = neg_r_q ? (~r_mag + 1'b1) : r_mag;
   assign q_fits  = neg_q_q ? (q_mag <= MIN_WORD) : !q_mag[W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= S_IDLE;
         rec_q    <= 1'b0;
         neg_q_q  <= 1'b0;
         neg_r_q  <= 1'b0;
         result_q <= '0;
         mq_q     <= '0;
         ov_q     <= 1'b0;
         so_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  rec_q <= op_in.rec_ov;
                  if (is_div_in) begin
                     if (special || too_big) begin
                        result_q <= MIN_WORD;
                        mq_q     <= '0;
                        if (op_in.rec_ov) begin
                           ov_q <= 1'b1;
                           so_q <= 1'b1;
                        end
                        state_q <= S_SPEC;
                     end else begin
                        neg_q_q <= neg_n ^ neg_d;
                        neg_r_q <= neg_n;
                        state_q <= S_DIV;
                     end
                  end else begin
                     state_q <= S_MUL;
                  end
               end
            end
            S_MUL: begin
               if (mul_fin) begin
                  result_q <= prod[2*W-1:W];
                  mq_q     <= prod[W-1:0];
                  if (rec_q) begin
                     ov_q <= mul_ov;
                     so_q <= so_q | mul_ov;
                  end
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            S_DIV: begin
               if (div_fin) begin
                  result_q <= q_fixed;
                  mq_q     <= r_fixed;
                  if (rec_q) begin
                     ov_q <= !q_fits;
                     so_q <= so_q | !q_fits;
                  end
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            S_SPEC: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign result_o = result_q;
   assign mq_o     = mq_q;
   assign ov_o     = ov_q;
   assign so_o     = so_q;
   assign done_o   = done_q;

   AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
      so_q |=> so_q);                                             // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);                                        // R8
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_IDLE && !start_i) |=>
         ($stable(result_q) && $stable(mq_q) && $stable(ov_q) && $stable(so_q))); // R8
   AST_OV_ONLY_RECORDING: assert property (@(posedge clk) disable iff (rst)
      !$stable(ov_q) |-> rec_q);                                  // R2
   AST_SPECIAL_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      (state_q == S_SPEC) |-> (result_q == MIN_WORD && mq_q == '0)); // R5

endmodule

// File: tb/sim_mdu_mq_unit.sv
module sim_mdu_mq_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [31:0] result_o, mq_o;
   logic        ov_o, so_o, done_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   localparam logic [2:0] OP_MUL = 3'b000, OP_MULO = 3'b001,
                          OP_DIV = 3'b010, OP_DIVO = 3'b011,
                          OP_DIVS = 3'b100, OP_DIVSO = 3'b101,
                          OP_RSV = 3'b110;

   always #5 clk = ~clk;

   mdu_mq_unit u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .result_o(result_o), .mq_o(mq_o), .ov_o(ov_o), .so_o(so_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Reference model written from the requirements.
   task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] mq_in, input logic ov_in, input logic so_in,
                        output logic [31:0] e_res, output logic [31:0] e_mq,
                        output logic e_ov, output logic e_so);
      logic rec;
      logic [1:0] kind;
      logic [63:0] p, n, nm, dm, qm, rm, q;
      logic negn, negd, special, fits;
      rec = op[0];
      kind = op[2:1];
      e_ov = ov_in;
      e_so = so_in;
      if (kind == 2'b01 || kind == 2'b10) begin
         n = (kind == 2'b01) ? {a, mq_in} : {{32{a[31]}}, a};
         special = (b == 32'h0) || (n[31:0] == 32'h80000000 && b == 32'hFFFFFFFF);
         negn = n[63];
         negd = b[31];
         nm = negn ? -n : n;
         dm = negd ? {32'h0, -b} : {32'h0, b};
         qm = special ? 64'h0 : nm / dm;
         rm = special ? 64'h0 : nm % dm;
         if (special || qm >= 64'h1_0000_0000) begin
            e_res = 32'h80000000;
            e_mq = 32'h0;
            if (rec) begin e_ov = 1'b1; e_so = 1'b1; end
         end else begin
            q = (negn ^ negd) ? -qm : qm;
            e_res = q[31:0];
            e_mq = negn ? (-rm[31:0]) : rm[31:0];
            fits = ($signed(q) >= -64'sd2147483648) && ($signed(q) <= 64'sd2147483647);
            if (rec) begin e_ov = !fits; e_so = so_in | !fits; end
         end
      end else begin
         p = {32'h0, a} * {32'h0, b};
         e_res = p[63:32];
         e_mq = p[31:0];
         if (rec) begin
            e_ov = (p != {{32{p[31]}}, p[31:0]});
            e_so = so_in | e_ov;
         end
      end
   endtask

   task automatic pulse_start(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(input string req, output bit got);
      int n = 0;
      while (!done_o && n < 200) begin @(negedge clk); n++; end
      got = done_o;
      chk(got, req, "done pulse seen", {31'h0, done_o}, 32'h1);
   endtask

   // Runs one operation and checks all outputs against the model.
   task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input string req);
      logic [31:0] er, em;
      logic eo, es;
      bit got;
      @(negedge clk);
      model(op, a, b, mq_o, ov_o, so_o, er, em, eo, es);
      pulse_start(op, a, b);
      wait_done(req, got);
      chk(result_o == er, req, "result", result_o, er);
      chk(mq_o == em, req, "mq", mq_o, em);
      chk(ov_o == eo, req, "ov", {31'h0, ov_o}, {31'h0, eo});
      chk(so_o == es, req, "so", {31'h0, so_o}, {31'h0, es});
      @(negedge clk);
      chk(!done_o, "R8", "done one cycle", {31'h0, done_o}, 32'h0);
      repeat (3) @(negedge clk);
      chk(result_o == er && mq_o == em && ov_o == eo && so_o == es, "R8",
          "outputs hold after done", result_o, er);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(result_o == 0 && mq_o == 0, "R9", "reset result/mq", result_o | mq_o, 32'h0);
      chk(!ov_o && !so_o && !done_o, "R9", "reset flags",
          {29'h0, ov_o, so_o, done_o}, 32'h0);
   endtask

   task automatic t_mul;
      run_op(OP_MUL, 32'h00010000, 32'h00010000, "R1");
      run_op(OP_MUL, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
      run_op(OP_RSV, 32'h12345678, 32'h9ABCDEF0, "R1");
      run_op(OP_MUL, 32'h80000000, 32'h00000003, "R2 plain mul keeps flags");
   endtask

   task automatic t_mulo;
      run_op(OP_MULO, 32'd3, 32'd5, "R2");
      run_op(OP_MULO, 32'h80000000, 32'd1, "R2");
      run_op(OP_MULO, 32'h00010000, 32'h00010000, "R2");
   endtask

   task automatic t_divs;
      run_op(OP_DIVS, 32'd7, 32'hFFFFFFFE, "R4");
      run_op(OP_DIVS, 32'hFFFFFFF9, 32'd2, "R4");
      run_op(OP_DIVSO, 32'd100, 32'd7, "R4");
      run_op(OP_DIVS, 32'hFFFFFF9C, 32'hFFFFFFF9, "R4");
   endtask

   task automatic t_divw;
      run_op(OP_MUL, 32'd1, 32'd100, "R1 load mq");
      run_op(OP_DIV, 32'd0, 32'd7, "R3");
      run_op(OP_MUL, 32'd3, 32'h9E3779B9, "R1 load mq");
      run_op(OP_DIV, 32'hFFFFFFFE, 32'd5, "R3");
      run_op(OP_MUL, 32'd7, 32'h12345, "R1 load mq");
      run_op(OP_DIVO, 32'd2, 32'hFFFFFFF0, "R3");
   endtask

   task automatic t_special;
      run_op(OP_DIVS, 32'd55, 32'd0, "R5");
      run_op(OP_DIVSO, 32'h80000000, 32'hFFFFFFFF, "R5");
      run_op(OP_MUL, 32'h80000000, 32'd1, "R5 load mq");
      run_op(OP_DIVO, 32'h00000000, 32'hFFFFFFFF, "R5");
   endtask

   task automatic t_range;
      run_op(OP_MUL, 32'd0, 32'd0, "R6 clear mq");
      run_op(OP_DIVO, 32'd5, 32'd2, "R6 oversize quotient");
      run_op(OP_MUL, 32'h80000000, 32'd1, "R6 load mq");
      run_op(OP_DIVO, 32'd0, 32'd1, "R6 quotient +2^31");
      run_op(OP_MUL, 32'h80000000, 32'd1, "R6 load mq");
      run_op(OP_DIVO, 32'hFFFFFFFF, 32'd1, "R6 quotient -2^31 fits");
      run_op(OP_MUL, 32'd0, 32'd0, "R6 clear mq");
      run_op(OP_DIV, 32'd9, 32'd3, "R6 plain oversize keeps flags");
   endtask

   task automatic t_sticky;
      run_op(OP_DIVSO, 32'd1, 32'd0, "R7 set so");
      run_op(OP_MULO, 32'd2, 32'd3, "R7");
      chk(so_o, "R7", "so survives clean op", {31'h0, so_o}, 32'h1);
      run_op(OP_DIVSO, 32'd9, 32'd3, "R7");
   endtask

   task automatic t_busy;
      logic [31:0] er, em;
      logic eo, es;
      bit got;
      int extra = 0;
      @(negedge clk);
      model(OP_DIVS, 32'd1000, 32'd13, mq_o, ov_o, so_o, er, em, eo, es);
      pulse_start(OP_DIVS, 32'd1000, 32'd13);
      repeat (2) @(negedge clk);
      pulse_start(OP_MUL, 32'd2, 32'd3);
      wait_done("R8", got);
      chk(result_o == er, "R8", "busy start ignored result", result_o, er);
      chk(mq_o == em, "R8", "busy start ignored mq", mq_o, em);
      repeat (60) begin @(negedge clk); if (done_o) extra++; end
      chk(extra == 0, "R8", "no second done", extra, 32'h0);
      chk(result_o == er && mq_o == em, "R8", "outputs unchanged", result_o, er);
   endtask

   task automatic t_reset_mid;
      int extra = 0;
      run_op(OP_DIVSO, 32'd3, 32'd0, "R9 set flags");
      pulse_start(OP_DIVS, 32'd77, 32'd5);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(result_o == 0 && mq_o == 0, "R9", "mid-op reset data", result_o | mq_o, 32'h0);
      chk(!ov_o && !so_o, "R9", "mid-op reset flags", {30'h0, ov_o, so_o}, 32'h0);
      repeat (50) begin @(negedge clk); if (done_o) extra++; end
      chk(extra == 0, "R9", "no done after reset", extra, 32'h0);
   endtask

   initial begin
      t_reset();
      t_mul();
      t_mulo();
      t_divs();
      t_divw();
      t_special();
      t_range();
      t_sticky();
      t_busy();
      t_reset_mid();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule